// File: doc/BRIEF.md
# Programmable Johnson Frequency Divider

This block divides its input clock by a whole ratio from 2 to 10, chosen at run time. Its core is a chain of five stages clocked together on the rising edge of the clock, wired as a twisted ring: every stage copies its lower neighbour, and the first stage takes an inverted copy of one stage further up. The ratio input decides how many stages take part in the ring and where the inverted feedback is taken from. An odd ratio is made by ANDing the inverses of two adjacent stages in the feedback path, which removes one state from the cycle.

A load strobe writes the inverse of a 5-bit jam word into the chain at any edge, overriding counting. If the stages inside the ring hold a pattern that a twisted ring never reaches, the chain is cleared on the next edge, so it always falls back into the selected cycle. The five stage values and a divided-clock output are visible at the ports.

Top module: `jdiv_counter`

## Requirements
- R1: While rst_ni is low, all five stages are 0 and div_o is 0. The clear is asynchronous and takes priority over everything else.
- R2: At a rising edge with load_i high, stage_o becomes the bitwise inverse of jam_i (stage_o[i] = ~jam_i[i]). This overrides counting, ratio and illegal-pattern clearing.
- R3: For an even effective ratio N = 2k, with load_i low and a legal ring, at each rising edge stage_o[0] takes the inverse of stage_o[k-1], stage_o[i] takes stage_o[i-1] for 1 <= i < k, and stage_o[i] for i >= k becomes 0.
- R4: For an odd effective ratio N = 2k-1, with load_i low and a legal ring, stage_o[0] takes (~stage_o[k-1]) & (~stage_o[k-2]); the other stages follow the same shift and zero rules as R3.
- R5: div_o is stage_o[k-1], with k = ceil(N/2). In steady state it rises exactly once every N clocks and stays high for floor(N/2) clocks of each period (a square wave for even N).
- R6: The effective ratio is ratio_i clamped to 2..10: ratio_i values 0 and 1 act as 2, values 11 to 15 act as 10.
- R7: If the ring stages stage_o[0..k-1] contain more than one change of level between adjacent stages, and load_i is low, all stages become 0 at the next rising edge.
- R8: A new ratio_i value governs the very next rising edge; after any change or load, stage_o follows the sequence of R3, R4 and R7 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all stages update on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low clear of the chain |
| ratio_i | input | 4 | Requested division ratio, clamped to 2..10 |
| load_i | input | 1 | Jam strobe; loads the inverted jam word |
| jam_i | input | 5 | Preset word, stored inverted on load |
| stage_o | output | 5 | Current stage values, bit i is stage i |
| div_o | output | 1 | Divided clock, one period every N input clocks |

## Verification
A wrong stage value shows at stage_o at the very next sampling point after the faulty edge, because the bench model is compared every clock; a wrong feedback tap or a missing AND term shows as a period on div_o that differs from N within one output period. A failure to clear an illegal ring pattern would leave a short parasitic cycle that the model mismatches one clock later. Jam inversion, stage zeroing above the ring and the ratio clamp are each visible directly on stage_o one edge after the stimulus.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;

  // clamp requested ratio into [2, nmax]
  function automatic int unsigned jd_clamp(input int unsigned r, input int unsigned nmax);
    if (r < 2) return 2;
    if (r > nmax) return nmax;
    return r;
  endfunction

  // number of ring stages for a ratio
  function automatic int unsigned jd_ring_len(input int unsigned n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/jdiv_tap_sel.sv
module jdiv_tap_sel
  import jdiv_pkg::*;
#(
  parameter int unsigned NSTG = 5,
  parameter int unsigned RW   = 4
) (
  input  logic [RW-1:0]   ratio_i,
  output logic [NSTG-1:0] ring_o,
  output logic [NSTG-1:0] tap_o,
  output logic            odd_o
);
  localparam int unsigned NMAX = 2 * NSTG;

  int unsigned n_eff;
  int unsigned k_len;

  always_comb begin
    n_eff = jd_clamp(32'(ratio_i), NMAX);
    k_len = jd_ring_len(n_eff);
    odd_o = n_eff[0];
    for (int i = 0; i < NSTG; i++) begin
      ring_o[i] = (i < k_len);
      tap_o[i]  = (i == k_len - 1);
    end
  end
endmodule

// File: rtl/jdiv_legal.sv
module jdiv_legal #(
  parameter int unsigned NSTG = 5
) (
  input  logic [NSTG-1:0] stage_i,
  input  logic [NSTG-1:0] ring_i,
  output logic            bad_o
);
  logic [NSTG-1:0] edge_v;

  assign edge_v[0] = 1'b0;
  for (genvar i = 1; i < NSTG; i++) begin : g_edge
    assign edge_v[i] = ring_i[i] & (stage_i[i] ^ stage_i[i-1]);
  end

  // a twisted ring pattern has at most one level change
  assign bad_o = ($countones(edge_v) > 1);
endmodule

// File: rtl/jdiv_chain.sv
module jdiv_chain #(
  parameter int unsigned NSTG = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [NSTG-1:0] jam_i,
  input  logic            clr_i,
  input  logic [NSTG-1:0] ring_i,
  input  logic [NSTG-1:0] tap_i,
  input  logic            odd_i,
  output logic [NSTG-1:0] stage_o,
  output logic            div_o
);
  logic [NSTG-1:0] stage_q;
  logic [NSTG-1:0] nxt;
  logic            fb_hi;
  logic            fb_lo;
  logic            fb;

  assign fb_hi = |(stage_q & tap_i);
  assign fb_lo = |(stage_q & (tap_i >> 1));
  assign fb    = odd_i ? (~fb_hi & ~fb_lo) : ~fb_hi;

  assign nxt[0] = fb;
  for (genvar i = 1; i < NSTG; i++) begin : g_shift
    assign nxt[i] = ring_i[i] & stage_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= '0;
    else if (load_i) stage_q <= ~jam_i;
    else if (clr_i)  stage_q <= '0;
    else             stage_q <= nxt;
  end

  assign stage_o = stage_q;
  assign div_o   = fb_hi;
endmodule

// File: rtl/jdiv_counter.sv
module jdiv_counter #(
  parameter int unsigned NSTG = 5,
  parameter int unsigned RW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RW-1:0]   ratio_i,
  input  logic            load_i,
  input  logic [NSTG-1:0] jam_i,
  output logic [NSTG-1:0] stage_o,
  output logic            div_o
);
  logic [NSTG-1:0] ring;
  logic [NSTG-1:0] tap;
  logic            odd;
  logic            bad;

  jdiv_tap_sel #(.NSTG(NSTG), .RW(RW)) u_tap (
    .ratio_i (ratio_i),
    .ring_o  (ring),
    .tap_o   (tap),
    .odd_o   (odd)
  );

  jdiv_legal #(.NSTG(NSTG)) u_legal (
    .stage_i (stage_o),
    .ring_i  (ring),
    .bad_o   (bad)
  );

  jdiv_chain #(.NSTG(NSTG)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .jam_i   (jam_i),
    .clr_i   (bad),
    .ring_i  (ring),
    .tap_i   (tap),
    .odd_i   (odd),
    .stage_o (stage_o),
    .div_o   (div_o)
  );
endmodule

// File: rtl/jdiv_counter_chk.sv
module jdiv_counter_chk
  import jdiv_pkg::*;
#(
  parameter int unsigned NSTG = 5,
  parameter int unsigned RW   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [RW-1:0]   ratio_i,
  input logic            load_i,
  input logic [NSTG-1:0] jam_i,
  input logic [NSTG-1:0] stage_o,
  input logic            div_o
);
  int unsigned     n_c;
  int unsigned     k_c;
  logic            odd_c;
  logic            exp_fb;
  logic            two_edges;
  logic [NSTG-1:0] in_ring;
  int unsigned     chg;

  always_comb begin
    n_c   = jd_clamp(32'(ratio_i), 2 * NSTG);
    k_c   = (n_c + 1) / 2;
    odd_c = (n_c % 2) == 1;
    chg   = 0;
    for (int i = 0; i < NSTG; i++) begin
      in_ring[i] = (i < k_c);
      if (i > 0 && i < k_c && stage_o[i] != stage_o[i-1]) chg++;
    end
    two_edges = (chg > 1);
    if (odd_c && k_c >= 2) exp_fb = !stage_o[k_c-1] && !stage_o[k_c-2];
    else                   exp_fb = !stage_o[k_c-1];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (stage_o == '0 && div_o == 1'b0);
    end
  end

  assert_load_inverts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> stage_o == ~$past(jam_i));

  assert_even_fb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !two_edges && !odd_c) |=> stage_o[0] == $past(exp_fb));

  assert_above_ring_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (stage_o & ~$past(in_ring)) == '0);

  assert_odd_fb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !two_edges && odd_c) |=> stage_o[0] == $past(exp_fb));

  assert_illegal_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && two_edges) |=> stage_o == '0);
endmodule

bind jdiv_counter jdiv_counter_chk #(.NSTG(NSTG), .RW(RW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ratio_i (ratio_i),
  .load_i  (load_i),
  .jam_i   (jam_i),
  .stage_o (stage_o),
  .div_o   (div_o)
);

// File: tb/jdiv_counter_tb.sv
module jdiv_counter_tb;
  localparam int NSTG = 5;
  localparam int RW   = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [RW-1:0]   ratio_i = 4'd10;
  logic            load_i = 1'b0;
  logic [NSTG-1:0] jam_i = '0;
  logic [NSTG-1:0] stage_o;
  logic            div_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  logic [NSTG-1:0] mdl;

  always #5 clk_i = ~clk_i;

  jdiv_counter #(.NSTG(NSTG), .RW(RW)) u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_i),
    .load_i  (load_i),
    .jam_i   (jam_i),
    .stage_o (stage_o),
    .div_o   (div_o)
  );

  function automatic int eff_ratio(input int r);
    if (r < 2) return 2;
    if (r > 2 * NSTG) return 2 * NSTG;
    return r;
  endfunction

  // behavioural next-state from the requirements
  function automatic logic [NSTG-1:0] ref_next(input logic [NSTG-1:0] s, input int r,
                                               input logic ld, input logic [NSTG-1:0] jam);
    logic [NSTG-1:0] o;
    int n, k, changes;
    if (ld) return ~jam;
    n = eff_ratio(r);
    k = (n + 1) / 2;
    changes = 0;
    for (int i = 1; i < k; i++) if (s[i] != s[i-1]) changes++;
    if (changes > 1) return '0;
    o = '0;
    if (n % 2 == 1) o[0] = !s[k-1] && !s[k-2];
    else            o[0] = !s[k-1];
    for (int i = 1; i < k; i++) o[i] = s[i-1];
    return o;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mdl <= '0;
    else         mdl <= ref_next(mdl, int'(ratio_i), load_i, jam_i);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    int n, k;
    n = eff_ratio(int'(ratio_i));
    k = (n + 1) / 2;
    chk(stage_o == mdl, cur_req, int'(stage_o), int'(mdl));
    chk(div_o == stage_o[k-1], "R5", int'(div_o), int'(stage_o[k-1]));
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic measure(input int r, input string req);
    int n, hi, rise_at, rises;
    logic p;
    n = eff_ratio(r);
    ratio_i = 4'(r);
    tick(3 * 2 * NSTG);
    rises = 0;
    for (int i = 0; i < 4 * n + 4; i++) begin
      p = div_o; tick();
      if (!p && div_o) begin rises = 1; break; end
    end
    chk(rises == 1, req, rises, 1);
    hi = 0; rises = 0; rise_at = 0;
    for (int i = 1; i <= n; i++) begin
      hi += int'(div_o);
      p = div_o; tick();
      if (!p && div_o) begin rises++; rise_at = i; end
    end
    chk(rises == 1 && rise_at == n, req, rise_at, n);
    chk(hi == n / 2, req, hi, n / 2);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    chk(stage_o == '0, "R1", int'(stage_o), 0);
    chk(div_o == 1'b0, "R1", int'(div_o), 0);
    rst_ni = 1'b1;
    tick(2);

    // periods for every ratio
    for (int r = 2; r <= 10; r++) begin
      cur_req = (r % 2 == 0) ? "R3" : "R4";
      measure(r, "R5");
    end

    // clamp of out-of-range ratios
    cur_req = "R6";
    measure(0, "R6");
    measure(1, "R6");
    measure(15, "R6");
    measure(11, "R6");

    // jam load is inverted and overrides counting
    cur_req = "R2";
    ratio_i = 4'd10;
    foreach (jam_pat[i]) begin
      jam_i = jam_pat[i]; load_i = 1'b1; tick();
      chk(stage_o == ~jam_pat[i], "R2", int'(stage_o), int'(~jam_pat[i]));
    end
    jam_i = 5'b00011; tick(3);
    chk(stage_o == 5'b11100, "R2", int'(stage_o), 28);
    load_i = 1'b0; tick(4);

    // illegal pattern cleared
    cur_req = "R7";
    ratio_i = 4'd10; jam_i = 5'b10101; load_i = 1'b1; tick();
    chk(stage_o == 5'b01010, "R2", int'(stage_o), 10);
    load_i = 1'b0; tick();
    chk(stage_o == 5'b00000, "R7", int'(stage_o), 0);
    tick(12);

    // stages above the ring drop to zero, ratio 4
    cur_req = "R3";
    jam_i = 5'b00000; load_i = 1'b1; tick();
    load_i = 1'b0; ratio_i = 4'd4; tick();
    chk(stage_o == 5'b00010, "R3", int'(stage_o), 2);

    // odd ratio 3 from full pattern
    cur_req = "R4";
    ratio_i = 4'd3; jam_i = 5'b00000; load_i = 1'b1; tick();
    load_i = 1'b0; tick();
    chk(stage_o == 5'b00010, "R4", int'(stage_o), 2);
    tick();
    chk(stage_o == 5'b00000, "R4", int'(stage_o), 0);
    tick();
    chk(stage_o == 5'b00001, "R4", int'(stage_o), 1);

    // ratio changes on the fly
    cur_req = "R8";
    for (int i = 0; i < 40; i++) begin
      ratio_i = 4'((i * 7 + 3) % 16);
      tick((i % 3) + 1);
    end
    ratio_i = 4'd6; tick(8);
    chk(stage_o == mdl, "R8", int'(stage_o), int'(mdl));

    // asynchronous reset mid-run
    cur_req = "R1";
    ratio_i = 4'd10; tick(3);
    #2 rst_ni = 1'b0;
    #1;
    chk(stage_o == '0, "R1", int'(stage_o), 0);
    chk(div_o == 1'b0, "R1", int'(div_o), 0);
    tick(2);
    rst_ni = 1'b1;
    tick(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [NSTG-1:0] jam_pat [3] = '{5'b00000, 5'b10110, 5'b11111};
endmodule